// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a 32-pin general-purpose I/O controller reached through a plain 32-bit register bus. Each pin runs in one of two modes. In general I/O mode a pin is an input, or an output driven from an output data latch. In interrupt-input mode the pin is never driven. Instead its conditioned input is compared against a selectable polarity and watched either for an edge or for an active level. Every pin has its own pending flag and its own enable bit. The enabled pending flags are ORed into one interrupt request line.

Pad inputs pass through a two-flop synchroniser. An optional per-pin glitch filter then accepts a new value only after it has been seen on two consecutive samples. The polarity register serves both modes. In general mode it inverts the driven output value and the value read back from the input data register.

Software services the interrupt line as follows. It reads the pending register, clears the bits it handles with write-1-to-clear writes, and repeats until the register reads zero. Pins are enabled through a separate unmask write port. A write to the mask register can only disable pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0. That means all pins are in general input mode, all are disabled, nothing is pending, `pad_oe` is 0 and `irq` is 0.
- R2: Registers at byte offsets 0x00 (mode, 1 = interrupt input), 0x04 (direction, 1 = output), 0x08 (output data), 0x20 (polarity) and 0x24 (sense, 1 = edge, 0 = level) read back what was written. A pin drives `pad_oe` = 1 exactly when its direction bit is 1 and its mode bit is 0. It then drives `pad_out` = output data XOR polarity. `pad_out` is 0 on a pin that is not driving. Both outputs follow a register write on the next clock.
- R3: A read of offset 0x0C returns the conditioned pad input XOR polarity, for all pins in either mode. The conditioned value reaches that register three clocks after `pad_in` is sampled when the filter is off: two synchroniser stages plus one conditioning stage.
- R4: For a pin with mode = 1 and sense = 1, a rising edge of (conditioned input XOR polarity) sets its bit in the pending register at 0x10. Polarity 0 therefore selects rising pad edges and polarity 1 selects falling pad edges. The bit stays set after the input returns to its inactive value.
- R5: For a pin with mode = 1 and sense = 0, the pending bit equals (conditioned input XOR polarity) one clock later. Writing its clear bit has no effect while that level is active.
- R6: Writing 1 to a bit of offset 0x14 clears that edge-mode pin's pending flag. Bits written as 0 leave their flags unchanged. An edge that arrives in the same clock as the clear leaves the flag set.
- R7: Writing the mask register at 0x18 disables every pin whose written bit is 0 and leaves pins whose bit is 1 unchanged. Writing 1 to a bit of offset 0x1C enables that pin. Reading 0x18 returns the enable bits, with 1 meaning enabled.
- R8: `irq` is 1 exactly when some pin has both its pending flag and its enable bit set.
- R9: For a pin whose bit is 1 in the filter register at 0x28, a pad pulse lasting one clock is rejected. A change held for two or more clocks is accepted, one clock later than with the filter off.
- R10: A pin in general I/O mode never has a pending flag. Switching a pin to general mode clears its flag on the next clock.
- R11: Reads of the write-only offsets 0x14 and 0x1C, of offsets above 0x28 and of addresses that are not word aligned return 0. Read data appears on `bus_rdata` in the clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Merged interrupt request |

## Verification
Directed sequences drive edge-mode pins with rising and falling pad edges under both polarities. The same sequences drive level-mode pins with active-low and active-high levels. This separates sticky edge capture from level following and shows that a clear write cannot defeat an active level. A one-clock pad pulse is applied to a filtered pin and an unfiltered pin side by side, which distinguishes glitch rejection from plain synchronisation. A pin left in general mode is toggled to show that it never pends. The mask and unmask ports are exercised with both 0 and 1 data bits to separate "disable only" from "enable only" behaviour. A long run then mixes random register writes, reads and pad toggles. It is compared on every clock against a behavioural model, which catches same-cycle races between an edge and a clear and between a mode change and detection.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        IDX_MODE  = 4'd0,
        IDX_DIR   = 4'd1,
        IDX_DOUT  = 4'd2,
        IDX_DIN   = 4'd3,
        IDX_PEND  = 4'd4,
        IDX_PCLR  = 4'd5,
        IDX_MASK  = 4'd6,
        IDX_MCLR  = 4'd7,
        IDX_POL   = 4'd8,
        IDX_SENSE = 4'd9,
        IDX_FILT  = 4'd10
    } reg_idx_e;

    localparam int LAST_IDX = 10;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              hit;
        reg_idx_e          idx;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic bus_req_t decode_req(input logic wr,
                                            input logic rd,
                                            input logic [ADDR_W-1:0] addr,
                                            input logic [DATA_W-1:0] wdata);
        bus_req_t r;
        logic [ADDR_W-3:0] word;
        word   = addr[ADDR_W-1:2];
        r.wr   = wr;
        r.rd   = rd;
        r.data = wdata;
        r.hit  = (addr[1:0] == 2'b00) && (int'(word) <= LAST_IDX);
        r.idx  = reg_idx_e'(word[IDX_W-1:0]);
        return r;
    endfunction

    function automatic logic is_write(input bus_req_t r, input reg_idx_e i);
        return r.wr && r.hit && (r.idx == i);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] filt,
    output logic [N-1:0] cond
);
    logic [N-1:0] s1_q, s2_q, s3_q, f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
            f_q  <= '0;
        end else begin
            s1_q <= pad_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
            for (int i = 0; i < N; i++) begin
                if (!filt[i] || (s2_q[i] == s3_q[i]))
                    f_q[i] <= s2_q[i];
            end
        end
    end

    assign cond = f_q;

    // filtered pins change only after two equal samples
    assert_filter_stable_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((f_q ^ $past(f_q)) & $past(filt) & $past(s2_q ^ s3_q)) == '0));

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] act, prev_q, edge_hit, pend_q, pend_n;

    assign act = cond ^ pol;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_comb begin
            edge_hit[g] = act[g] & ~prev_q[g] & mode[g] & sense[g];
            if (!mode[g])
                pend_n[g] = 1'b0;
            else if (!sense[g])
                pend_n[g] = act[g];
            else if (edge_hit[g])
                pend_n[g] = 1'b1;
            else
                pend_n[g] = pend_q[g] & ~clr[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= act;
            pend_q <= pend_n;
        end
    end

    assign pend = pend_q;

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((pend_q & $past(clr & ~edge_hit & mode & sense)) == '0));

    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr) & $past(mode & sense)) == '0));

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_q ^ $past(act)) & $past(mode & ~sense)) == '0));

    assert_general_nopend_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(mode)) == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [N-1:0]      din,
    input  logic [N-1:0]      pend,
    output logic [N-1:0]      mode,
    output logic [N-1:0]      dir,
    output logic [N-1:0]      dout,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      sense,
    output logic [N-1:0]      filt,
    output logic [N-1:0]      en,
    output logic [N-1:0]      clr,
    output logic [DATA_W-1:0] rdata
);
    logic [N-1:0]      wd;
    logic [N-1:0]      rsel;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] rdata_q;

    assign wd  = req.data[N-1:0];
    assign clr = is_write(req, IDX_PCLR) ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= '0;
            dir   <= '0;
            dout  <= '0;
            pol   <= '0;
            sense <= '0;
            filt  <= '0;
            en    <= '0;
        end else begin
            if (is_write(req, IDX_MODE))  mode  <= wd;
            if (is_write(req, IDX_DIR))   dir   <= wd;
            if (is_write(req, IDX_DOUT))  dout  <= wd;
            if (is_write(req, IDX_POL))   pol   <= wd;
            if (is_write(req, IDX_SENSE)) sense <= wd;
            if (is_write(req, IDX_FILT))  filt  <= wd;
            if (is_write(req, IDX_MASK))
                en <= en & wd;
            else if (is_write(req, IDX_MCLR))
                en <= en | wd;
        end
    end

    always_comb begin
        rsel = '0;
        if (req.hit) begin
            case (req.idx)
                IDX_MODE:  rsel = mode;
                IDX_DIR:   rsel = dir;
                IDX_DOUT:  rsel = dout;
                IDX_DIN:   rsel = din ^ pol;
                IDX_PEND:  rsel = pend;
                IDX_MASK:  rsel = en;
                IDX_POL:   rsel = pol;
                IDX_SENSE: rsel = sense;
                IDX_FILT:  rsel = filt;
                default:   rsel = '0;
            endcase
        end
        rword         = '0;
        rword[N-1:0]  = rsel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (req.rd)
            rdata_q <= rword;
    end

    assign rdata = rdata_q;

    assert_mask_disables_R7: assert property (@(posedge clk) disable iff (rst)
        is_write(req, IDX_MASK) |=> ((en & ~$past(wd)) == '0));

    assert_unmask_enables_R7: assert property (@(posedge clk) disable iff (rst)
        is_write(req, IDX_MCLR) |=> ((~en & $past(wd)) == '0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(rdata_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    bus_req_t         req;
    logic [NPINS-1:0] mode, dir, dout, pol, sense, filt, en, clr;
    logic [NPINS-1:0] cond, pend;

    assign req = decode_req(bus_wr, bus_rd, bus_addr, bus_wdata);

    gpio_regs #(.N(NPINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .din   (cond),
        .pend  (pend),
        .mode  (mode),
        .dir   (dir),
        .dout  (dout),
        .pol   (pol),
        .sense (sense),
        .filt  (filt),
        .en    (en),
        .clr   (clr),
        .rdata (bus_rdata)
    );

    gpio_sync #(.N(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .filt   (filt),
        .cond   (cond)
    );

    gpio_detect #(.N(NPINS)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond),
        .pol   (pol),
        .mode  (mode),
        .sense (sense),
        .clr   (clr),
        .pend  (pend)
    );

    assign pad_oe  = dir & ~mode;
    assign pad_out = (dout ^ pol) & pad_oe;
    assign irq     = |(pend & en);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(pend & en) == '0) && ((pend & en) != '0));

    assert_intr_pin_undriven_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pad_oe & $past(mode)) == '0) || is_write($past(req), IDX_MODE));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_mode, m_dir, m_dout, m_pol, m_sense, m_filt, m_en, m_pend, m_rdata;
    logic [31:0] m_h1, m_h2, m_h3, m_f, m_prev;
    string       m_rtag = "R1";

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h0C) return "R3";
        if (a == 8'h10) return "R4";
        if (a == 8'h18) return "R7";
        if (a == 8'h28) return "R9";
        if (a[1:0] != 0 || a > 8'h28 || a == 8'h14 || a == 8'h1C) return "R11";
        return "R2";
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            8'h00: return m_mode;
            8'h04: return m_dir;
            8'h08: return m_dout;
            8'h0C: return m_f ^ m_pol;
            8'h10: return m_pend;
            8'h18: return m_en;
            8'h20: return m_pol;
            8'h24: return m_sense;
            8'h28: return m_filt;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] act, rise, clrv, nxt, keep;
        if (rst) begin
            m_mode = 0; m_dir = 0; m_dout = 0; m_pol = 0; m_sense = 0; m_filt = 0;
            m_en = 0; m_pend = 0; m_rdata = 0;
            m_h1 = 0; m_h2 = 0; m_h3 = 0; m_f = 0; m_prev = 0;
        end else begin
            act  = m_f ^ m_pol;
            rise = act & ~m_prev & m_mode & m_sense;
            clrv = (bus_wr && bus_addr == 8'h14) ? bus_wdata : 32'h0;
            nxt  = m_mode & ((~m_sense & act) | (m_sense & (rise | (m_pend & ~clrv))));
            if (bus_rd) begin
                m_rdata = m_read(bus_addr);
                m_rtag  = tag_of(bus_addr);
            end
            m_prev = act;
            keep   = m_filt & (m_h2 ^ m_h3);
            m_f    = (keep & m_f) | (~keep & m_h2);
            m_h3   = m_h2;
            m_h2   = m_h1;
            m_h1   = pad_in;
            m_pend = nxt;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_mode  = bus_wdata;
                    8'h04: m_dir   = bus_wdata;
                    8'h08: m_dout  = bus_wdata;
                    8'h18: m_en    = m_en & bus_wdata;
                    8'h1C: m_en    = m_en | bus_wdata;
                    8'h20: m_pol   = bus_wdata;
                    8'h24: m_sense = bus_wdata;
                    8'h28: m_filt  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare with the reference on every clock, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk("R2 pad_oe", pad_oe, m_dir & ~m_mode);
            chk("R2 pad_out", pad_out, (m_dout ^ m_pol) & m_dir & ~m_mode);
            chk("R8 irq", {31'b0, irq}, {31'b0, |(m_pend & m_en)});
            chk({m_rtag, " rdata"}, bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pad_oe in reset", pad_oe, 32'h0);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst = 1'b0;
        live = 1'b1;

        // R1 reset values
        rdx(8'h00, 32'h0, "R1 mode");
        rdx(8'h18, 32'h0, "R1 mask");
        rdx(8'h10, 32'h0, "R1 pending");
        rdx(8'h0C, 32'h0, "R1 input");

        // R2 output drive
        wr(8'h08, 32'hA5A5_0F0F);
        wr(8'h04, 32'h0000_FFFF);
        chk("R2 oe", pad_oe, 32'h0000_FFFF);
        chk("R2 out", pad_out, 32'h0000_0F0F);
        wr(8'h20, 32'h0000_0001);
        chk("R2 out inverted", pad_out, 32'h0000_0F0E);
        wr(8'h00, 32'h0000_0002);
        chk("R2 intr pin undriven", pad_oe, 32'h0000_FFFD);
        chk("R2 intr pin out", pad_out, 32'h0000_0F0C);
        rdx(8'h08, 32'hA5A5_0F0F, "R2 dout readback");
        wr(8'h00, 32'h0);
        wr(8'h20, 32'h0);
        wr(8'h04, 32'h0);

        // R3 input data
        pad(32'h1234_5678);
        idle(4);
        rdx(8'h0C, 32'h1234_5678, "R3 input");
        wr(8'h20, 32'h0000_00FF);
        rdx(8'h0C, 32'h1234_5687, "R3 input inverted");
        wr(8'h20, 32'h0);
        pad(32'h0);
        idle(5);

        // R4 edge detection, bit0 rising, bit1 falling
        pad(32'h2);
        idle(5);
        wr(8'h20, 32'h2);
        wr(8'h24, 32'hF);
        wr(8'h00, 32'hF);
        wr(8'h14, 32'hF);
        pad(32'h1);
        idle(5);
        pad(32'h0);
        idle(5);
        rdx(8'h10, 32'h3, "R4 edges captured");
        chk("R8 masked irq low", {31'b0, irq}, 32'h0);

        // R7 / R8 mask ports
        wr(8'h1C, 32'h2);
        rdx(8'h18, 32'h2, "R7 unmask");
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'hFFFF_FFFD);
        rdx(8'h18, 32'h0, "R7 mask write");
        chk("R8 irq low after mask", {31'b0, irq}, 32'h0);
        wr(8'h1C, 32'h3);
        wr(8'h18, 32'hFFFF_FFFF);
        rdx(8'h18, 32'h3, "R7 ones leave enables");

        // R6 write-1-to-clear
        wr(8'h14, 32'h1);
        rdx(8'h10, 32'h2, "R6 clear bit0");
        chk("R8 irq still high", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h0);
        rdx(8'h10, 32'h2, "R6 zero has no effect");
        wr(8'h14, 32'h2);
        rdx(8'h10, 32'h0, "R6 clear bit1");
        chk("R8 irq low", {31'b0, irq}, 32'h0);

        // R5 level detection, bit4 active high, bit5 active low
        wr(8'h20, 32'h22);
        wr(8'h00, 32'h3F);
        idle(3);
        rdx(8'h10, 32'h20, "R5 active low level");
        wr(8'h14, 32'h20);
        rdx(8'h10, 32'h20, "R5 clear ignored while active");
        pad(32'h30);
        idle(5);
        rdx(8'h10, 32'h10, "R5 levels follow");
        pad(32'h0);
        idle(5);
        rdx(8'h10, 32'h20, "R5 levels return");

        // R10 general mode pins
        pad(32'h100);
        idle(5);
        pad(32'h0);
        idle(5);
        wr(8'h00, 32'hF);
        rdx(8'h10, 32'h0, "R10 general pins never pend");

        // R9 filter
        wr(8'h28, 32'h4);
        pad(32'hC);
        pad(32'h0);
        idle(6);
        rdx(8'h10, 32'h8, "R9 pulse rejected on filtered pin");
        pad(32'h4);
        idle(6);
        rdx(8'h10, 32'hC, "R9 held change accepted");
        wr(8'h14, 32'hFFFF_FFFF);
        pad(32'h0);
        idle(6);

        // R11 write-only and unmapped reads
        rdx(8'h14, 32'h0, "R11 clear port reads 0");
        rdx(8'h1C, 32'h0, "R11 unmask port reads 0");
        rdx(8'h2C, 32'h0, "R11 unmapped");
        rdx(8'h01, 32'h0, "R11 unaligned");

        // mixed random traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            int op;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            op = $urandom % 10;
            if (op < 3) begin
                bus_wr = 1'b1;
                bus_addr = 8'(($urandom % 12) << 2);
                bus_wdata = $urandom;
            end else if (op < 6) begin
                bus_rd = 1'b1;
                bus_addr = 8'(($urandom % 12) << 2);
            end
            if (($urandom % 3) == 0)
                pad_in = pad_in ^ (32'h1 << ($urandom % 32));
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule